// File: doc/BRIEF.md
# Host Command Decoder with GPIO Interrupt Causes

This block sits behind a host link whose framing has already been removed. The link hands it one byte at a time, and a flag marks the first byte of each transfer as a command. The block turns each command into a register write, a read response, or an error. It holds the settings that the neighbouring blocks use: debounce time, PWM high and low periods, PWM control, and the direction and output levels of four general-purpose pins. Other blocks own the PWM counter and the key-event FIFO. This block only drives their settings and pop strobe.

Pins 0 and 1 can raise interrupts. Each passes through a two-stage synchronizer, and any change of level latches a cause bit. The host reads the interrupt code to learn the causes, and that read clears them. Three sticky error flags are also held and reported: an unrecognised command byte, a command that arrives while an earlier command still waits for data, and an interrupt source that reverts before the host has serviced it.

Top module: `host_cmd_unit`

## Requirements
- R1: After reset, every setting register, `gpioOut`, `gpioOe`, `errFlags`, `irq` and `rspValid` is zero.
- R2: Commands 0x22 (debounce), 0x31 (pin outputs, bits 3..0), 0x32 (pin direction, bits 3..0, 1 = drive) and 0x42 (PWM control) each take one data byte. The register updates at the clock edge that accepts that byte.
- R3: Commands 0x40 (PWM high) and 0x41 (PWM low) take two data bytes, least significant first. Each byte lands in its own lane as it arrives.
- R4: A read command (0x20, 0x21, 0x30 or 0xD0) accepted while idle raises `rspValid` for exactly one cycle, in the cycle after the command byte, with the result on `rspData`.
- R5: Command 0x20 pulses `fifoPop` in the same cycle as the command byte and returns `fifoData`. Command 0x21 returns the byte from the last 0x20 again, without a pop.
- R6: Command 0x30 returns the live levels of the four input pins in bits 3..0, with bits 7..4 at zero.
- R7: A change of level on pin 0 or pin 1 sets cause bit 0 or 1 a few cycles later, and `irq` rises. Changes on pins 2 and 3 set no cause.
- R8: Command 0xD0 returns bit 2 = any error flag set and bits 1..0 = cause bits. It then clears the cause bits and all error flags, so `irq` falls.
- R9: An unrecognised command byte sets `errFlags` bit 0 and changes no other register.
- R10: A command byte that arrives while an earlier write still waits for data sets `errFlags` bit 1 and is dropped. The earlier write then completes with the next data byte.
- R11: A second change on an interrupt pin whose cause bit is still pending sets `errFlags` bit 2.
- R12: A data byte that arrives while no write is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is present on `rxByte` this cycle |
| cmdStart | input | 1 | The present byte is a command byte |
| rxByte | input | 8 | Byte from the host link |
| fifoData | input | 8 | Head of the key-event FIFO |
| fifoPop | output | 1 | Pops the key-event FIFO |
| gpioIn | input | 4 | Pin input levels |
| gpioOut | output | 4 | Pin output levels |
| gpioOe | output | 4 | Pin drive enables |
| debounce | output | 8 | Debounce setting |
| pwmHigh | output | 16 | PWM high period |
| pwmLow | output | 16 | PWM low period |
| pwmCtl | output | 8 | PWM control byte |
| rspValid | output | 1 | Read response valid |
| rspData | output | 8 | Read response byte |
| irq | output | 1 | Interrupt request: a cause or an error flag is pending |
| errFlags | output | 3 | Sticky errors: bit 2 missed interrupt, bit 1 overrun, bit 0 unknown |

## Verification
The bench interleaves a command byte into an unfinished write. A design that let that command through would change the direction register, or would abandon the pending write and leave the output register stale. It reads the interrupt code while an error is pending, to catch a packing in which the error summary bit or the cause bits sit in the wrong lane. It also reverts an interrupt pin before the service read, which a design without missed-interrupt tracking would report as an ordinary cause. Writes to the two-byte PWM registers are checked part-way through, so a byte-lane mix-up shows up. A repeated FIFO read with a changed FIFO head shows whether the design pops again or returns fresh data.

// File: rtl/hcu_pkg.sv
package hcu_pkg;
  localparam int IDX_W = 2;

  localparam logic [7:0] CMD_FIFO    = 8'h20;
  localparam logic [7:0] CMD_FIFO_RP = 8'h21;
  localparam logic [7:0] CMD_DEB     = 8'h22;
  localparam logic [7:0] CMD_GIN     = 8'h30;
  localparam logic [7:0] CMD_GOUT    = 8'h31;
  localparam logic [7:0] CMD_GDIR    = 8'h32;
  localparam logic [7:0] CMD_PHI     = 8'h40;
  localparam logic [7:0] CMD_PLO     = 8'h41;
  localparam logic [7:0] CMD_PCTL    = 8'h42;
  localparam logic [7:0] CMD_INT     = 8'hD0;

  typedef enum logic [2:0] {
    TG_NONE, TG_DEB, TG_GOUT, TG_GDIR, TG_PHI, TG_PLO, TG_PCTL
  } tgtE;

  typedef enum logic [2:0] {
    RD_NONE, RD_FIFO, RD_AGAIN, RD_GPIO, RD_INT
  } rdE;

  typedef struct packed {
    logic             wrEn;
    tgtE              tgt;
    logic [IDX_W-1:0] idx;
    rdE               rd;
    logic             errUnk;
    logic             errOvr;
  } strobeT;
endpackage

// File: rtl/hcu_ctrl.sv
module hcu_ctrl
  import hcu_pkg::*;
#(
  parameter int PWM_BYTES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       cmdStart,
  input  logic [7:0] rxByte,
  output strobeT     stb,
  output logic       busy
);
  tgtE              tgtQ, tgtN;
  logic [IDX_W-1:0] idxQ, idxN;
  logic             busyN;
  logic             isCmd, isData;

  function automatic logic [IDX_W-1:0] lastIdx(input tgtE t);
    if (t == TG_PHI || t == TG_PLO) return IDX_W'(PWM_BYTES - 1);
    return '0;
  endfunction

  always_comb begin
    stb    = '0;
    busyN  = busy;
    tgtN   = tgtQ;
    idxN   = idxQ;
    isCmd  = byteValid & cmdStart;
    isData = byteValid & ~cmdStart & busy;
    if (isCmd) begin
      if (busy) begin
        stb.errOvr = 1'b1;
      end else begin
        idxN = '0;
        case (rxByte)
          CMD_FIFO:    stb.rd = RD_FIFO;
          CMD_FIFO_RP: stb.rd = RD_AGAIN;
          CMD_GIN:     stb.rd = RD_GPIO;
          CMD_INT:     stb.rd = RD_INT;
          CMD_DEB:     begin busyN = 1'b1; tgtN = TG_DEB;  end
          CMD_GOUT:    begin busyN = 1'b1; tgtN = TG_GOUT; end
          CMD_GDIR:    begin busyN = 1'b1; tgtN = TG_GDIR; end
          CMD_PHI:     begin busyN = 1'b1; tgtN = TG_PHI;  end
          CMD_PLO:     begin busyN = 1'b1; tgtN = TG_PLO;  end
          CMD_PCTL:    begin busyN = 1'b1; tgtN = TG_PCTL; end
          default:     stb.errUnk = 1'b1;
        endcase
      end
    end else if (isData) begin
      stb.wrEn = 1'b1;
      stb.tgt  = tgtQ;
      stb.idx  = idxQ;
      if (idxQ == lastIdx(tgtQ)) begin
        busyN = 1'b0;
        tgtN  = TG_NONE;
      end else begin
        idxN = idxQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      tgtQ <= TG_NONE;
      idxQ <= '0;
    end else begin
      busy <= busyN;
      tgtQ <= tgtN;
      idxQ <= idxN;
    end
  end
endmodule

// File: rtl/hcu_dp.sv
module hcu_dp
  import hcu_pkg::*;
#(
  parameter int GPIO_N = 4,
  parameter int IRQ_N  = 2,
  parameter int PWM_W  = 16,
  parameter int DEB_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [7:0]        rxByte,
  input  logic [7:0]        fifoData,
  input  logic [GPIO_N-1:0] gpioIn,
  output logic              fifoPop,
  output logic [GPIO_N-1:0] gpioOut,
  output logic [GPIO_N-1:0] gpioOe,
  output logic [DEB_W-1:0]  debounce,
  output logic [PWM_W-1:0]  pwmHigh,
  output logic [PWM_W-1:0]  pwmLow,
  output logic [7:0]        pwmCtl,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              irq,
  output logic [2:0]        errFlags
);
  localparam int PWM_BYTES = PWM_W / 8;

  logic [IRQ_N-1:0] syncA, syncB, prevLvl, pinEdge, cause, causeN;
  logic [2:0]       errN;
  logic [7:0]       lastFifo, rspN, intCode;
  logic             clrInt;

  for (genvar p = 0; p < IRQ_N; p++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA[p]   <= 1'b0;
        syncB[p]   <= 1'b0;
        prevLvl[p] <= 1'b0;
      end else begin
        syncA[p]   <= gpioIn[p];
        syncB[p]   <= syncA[p];
        prevLvl[p] <= syncB[p];
      end
    end
    assign pinEdge[p] = syncB[p] ^ prevLvl[p];
  end

  assign fifoPop = (stb.rd == RD_FIFO);
  assign clrInt  = (stb.rd == RD_INT);
  assign intCode = 8'({|errFlags, cause});
  assign causeN  = (clrInt ? '0 : cause) | pinEdge;
  assign errN    = (clrInt ? 3'b000 : errFlags)
                 | {|(pinEdge & cause), stb.errOvr, stb.errUnk};
  assign irq     = (|cause) | (|errFlags);

  always_comb begin
    case (stb.rd)
      RD_FIFO:  rspN = fifoData;
      RD_AGAIN: rspN = lastFifo;
      RD_GPIO:  rspN = 8'(gpioIn);
      RD_INT:   rspN = intCode;
      default:  rspN = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpioOut  <= '0;
      gpioOe   <= '0;
      debounce <= '0;
      pwmHigh  <= '0;
      pwmLow   <= '0;
      pwmCtl   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      lastFifo <= '0;
      cause    <= '0;
      errFlags <= '0;
    end else begin
      rspValid <= (stb.rd != RD_NONE);
      rspData  <= rspN;
      cause    <= causeN;
      errFlags <= errN;
      if (fifoPop) lastFifo <= fifoData;
      if (stb.wrEn) begin
        case (stb.tgt)
          TG_DEB:  debounce <= rxByte[DEB_W-1:0];
          TG_GOUT: gpioOut  <= rxByte[GPIO_N-1:0];
          TG_GDIR: gpioOe   <= rxByte[GPIO_N-1:0];
          TG_PCTL: pwmCtl   <= rxByte;
          TG_PHI:
            for (int b = 0; b < PWM_BYTES; b++)
              if (stb.idx == IDX_W'(b)) pwmHigh[b*8 +: 8] <= rxByte;
          TG_PLO:
            for (int b = 0; b < PWM_BYTES; b++)
              if (stb.idx == IDX_W'(b)) pwmLow[b*8 +: 8] <= rxByte;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/host_cmd_unit.sv
module host_cmd_unit
  import hcu_pkg::*;
#(
  parameter int GPIO_N = 4,
  parameter int IRQ_N  = 2,
  parameter int PWM_W  = 16,
  parameter int DEB_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              cmdStart,
  input  logic [7:0]        rxByte,
  input  logic [7:0]        fifoData,
  output logic              fifoPop,
  input  logic [GPIO_N-1:0] gpioIn,
  output logic [GPIO_N-1:0] gpioOut,
  output logic [GPIO_N-1:0] gpioOe,
  output logic [DEB_W-1:0]  debounce,
  output logic [PWM_W-1:0]  pwmHigh,
  output logic [PWM_W-1:0]  pwmLow,
  output logic [7:0]        pwmCtl,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              irq,
  output logic [2:0]        errFlags
);
  strobeT stb;
  logic   ctrlBusy;

  hcu_ctrl #(.PWM_BYTES(PWM_W / 8)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .cmdStart(cmdStart),
    .rxByte(rxByte), .stb(stb), .busy(ctrlBusy)
  );

  hcu_dp #(.GPIO_N(GPIO_N), .IRQ_N(IRQ_N), .PWM_W(PWM_W), .DEB_W(DEB_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte), .fifoData(fifoData),
    .gpioIn(gpioIn), .fifoPop(fifoPop), .gpioOut(gpioOut), .gpioOe(gpioOe),
    .debounce(debounce), .pwmHigh(pwmHigh), .pwmLow(pwmLow), .pwmCtl(pwmCtl),
    .rspValid(rspValid), .rspData(rspData), .irq(irq), .errFlags(errFlags)
  );
endmodule

// File: rtl/host_cmd_unit_chk.sv
module host_cmd_unit_chk #(
  parameter int GPIO_N = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic              cmdStart,
  input logic              fifoPop,
  input logic [GPIO_N-1:0] gpioOe,
  input logic              rspValid,
  input logic [2:0]        errFlags,
  input logic              ctrlBusy
);
  // R4
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(byteValid && cmdStart && !ctrlBusy));
  // R9
  unknown_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlags[0]) |-> $past(byteValid && cmdStart && !ctrlBusy));
  // R10
  overrun_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlags[1]) |-> $past(byteValid && cmdStart && ctrlBusy));
  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlBusy) |-> $past(byteValid && !cmdStart));
  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> $stable(gpioOe));
  // R5
  pop_on_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (byteValid && cmdStart && !ctrlBusy));
endmodule

bind host_cmd_unit host_cmd_unit_chk #(.GPIO_N(GPIO_N)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .cmdStart(cmdStart),
  .fifoPop(fifoPop), .gpioOe(gpioOe), .rspValid(rspValid),
  .errFlags(errFlags), .ctrlBusy(ctrlBusy)
);

// File: tb/host_cmd_unit_bench.sv
module host_cmd_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic        cmdStart = 1'b0;
  logic [7:0]  rxByte = 8'h00;
  logic [7:0]  fifoData = 8'h00;
  logic [3:0]  gpioIn = 4'h0;
  logic        fifoPop, rspValid, irq;
  logic [3:0]  gpioOut, gpioOe;
  logic [7:0]  debounce, pwmCtl, rspData;
  logic [15:0] pwmHigh, pwmLow;
  logic [2:0]  errFlags;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  host_cmd_unit u_host_cmd_unit (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .cmdStart(cmdStart),
    .rxByte(rxByte), .fifoData(fifoData), .fifoPop(fifoPop), .gpioIn(gpioIn),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .debounce(debounce), .pwmHigh(pwmHigh),
    .pwmLow(pwmLow), .pwmCtl(pwmCtl), .rspValid(rspValid), .rspData(rspData),
    .irq(irq), .errFlags(errFlags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare each response against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      vectors++;
      if (expQ.size() == 0) begin
        misses++;
        $display("FAIL R4 unexpected response actual=%0h expected=none", rspData);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (rspData !== e) begin
          misses++;
          $display("FAIL %s actual=%0h expected=%0h", t, rspData, e);
        end
      end
    end
  end

  task automatic sendByte(input logic start, input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    cmdStart  = start;
    rxByte    = b;
    @(negedge clk);
    byteValid = 1'b0;
    cmdStart  = 1'b0;
  endtask

  task automatic readCmd(input logic [7:0] code, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    sendByte(1'b1, code);
  endtask

  task automatic wait4();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 gpioOe", gpioOe, 0);
    check("R1 gpioOut", gpioOut, 0);
    check("R1 pwmHigh", pwmHigh, 0);
    check("R1 irq", irq, 0);
    check("R1 errFlags", errFlags, 0);
    check("R1 debounce", debounce, 0);

    // R2 single-byte writes
    sendByte(1, 8'h22); sendByte(0, 8'h5A);
    check("R2 debounce", debounce, 8'h5A);
    sendByte(1, 8'h32); sendByte(0, 8'h0C);
    check("R2 gpioOe", gpioOe, 4'hC);
    sendByte(1, 8'h31); sendByte(0, 8'hF6);
    check("R2 gpioOut", gpioOut, 4'h6);
    sendByte(1, 8'h42); sendByte(0, 8'h81);
    check("R2 pwmCtl", pwmCtl, 8'h81);

    // R3 two-byte PWM writes, low byte first
    sendByte(1, 8'h40); sendByte(0, 8'h34);
    check("R3 pwmHigh half", pwmHigh, 16'h0034);
    sendByte(0, 8'h12);
    check("R3 pwmHigh", pwmHigh, 16'h1234);
    sendByte(1, 8'h41); sendByte(0, 8'hCD); sendByte(0, 8'hAB);
    check("R3 pwmLow", pwmLow, 16'hABCD);

    // R6 gpio read; R7 pins 2,3 raise nothing
    gpioIn = 4'b1100;
    wait4();
    readCmd(8'h30, 8'h0C, "R6 gpio read");
    check("R7 no irq from pins 2,3", irq, 0);

    // R5 fifo read then repeated read without pop
    fifoData = 8'h77;
    expQ.push_back(8'h77); tagQ.push_back("R5 fifo read");
    @(negedge clk);
    byteValid = 1; cmdStart = 1; rxByte = 8'h20;
    #1 check("R5 pop pulse", fifoPop, 1);
    @(negedge clk);
    byteValid = 0; cmdStart = 0;
    fifoData = 8'h99;
    expQ.push_back(8'h77); tagQ.push_back("R5 repeat read");
    @(negedge clk);
    byteValid = 1; cmdStart = 1; rxByte = 8'h21;
    #1 check("R5 no pop on repeat", fifoPop, 0);
    @(negedge clk);
    byteValid = 0; cmdStart = 0;

    // R9 unknown command
    sendByte(1, 8'h55);
    check("R9 unknown flag", errFlags, 3'b001);
    check("R9 gpioOut untouched", gpioOut, 4'h6);
    check("R9 irq", irq, 1);
    // R8 read clears errors
    readCmd(8'hD0, 8'h04, "R8 int code with error");
    check("R8 errFlags cleared", errFlags, 0);
    check("R8 irq cleared", irq, 0);

    // R10 overrun: command dropped, earlier write completes
    sendByte(1, 8'h31);
    sendByte(1, 8'h32);
    sendByte(0, 8'h09);
    check("R10 gpioOut completed", gpioOut, 4'h9);
    check("R10 gpioOe unchanged", gpioOe, 4'hC);
    check("R10 overrun flag", errFlags, 3'b010);
    readCmd(8'hD0, 8'h04, "R10 int code");

    // R12 stray data byte
    sendByte(0, 8'hFF);
    check("R12 gpioOut", gpioOut, 4'h9);
    check("R12 errFlags", errFlags, 0);

    // R7 pin 0 change latches cause
    gpioIn = 4'b1101;
    wait4();
    check("R7 irq on pin0", irq, 1);
    readCmd(8'hD0, 8'h01, "R7 cause bit 0");
    check("R8 irq after read", irq, 0);

    // R11 pin 1 reverts before service
    gpioIn = 4'b1111;
    wait4();
    gpioIn = 4'b1101;
    wait4();
    check("R11 noint flag", errFlags, 3'b100);
    readCmd(8'hD0, 8'h06, "R11 int code");
    check("R11 irq cleared", irq, 0);

    readCmd(8'h30, 8'h0D, "R6 gpio read 2");
    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule